// File: doc/BRIEF.md
# Interrupt-on-Change Port Expander Core

This block is the register file and pin logic of a sixteen-pin port expander split into two eight-bit banks. A host reaches it over a plain synchronous register bus: a byte address, write data with a write strobe, and a read strobe whose data comes back on the following cycle. The bus has no stall and no back-pressure. An access is accepted in the cycle its strobe is high, and the read data register holds its value until the next read. The serial transport in front of the bus and the pad cells behind the pin signals belong to other blocks.

Each pin has a direction bit, an output latch bit and a pull-up enable. Inputs pass through a two-flop synchronizer and an optional per-pin inversion. Each bank then watches its enabled input pins for an interrupt condition. A pin is in one of two modes: it can fire on any change from the value it had in the previous cycle, or it can fire whenever it differs from a per-pin compare value. When a bank fires, it flags only the first pin that fired and snapshots its whole port value. Both stay frozen until a clearing read. Two interrupt pins report the banks, either one per bank or both combined. Their polarity and their push-pull or open-drain style are set from a configuration register that both banks share.

Top module: `gx_core`

## Requirements
- R1: After reset every direction bit is 1, so all pins are inputs and undriven (`gpio_oe_n` all ones). Every other writable register is zero, and both interrupt pins are inactive: push-pull, active low, so the level is 1 with the enable at 0.
- R2: Byte address = register index × 2 + bank, with bank A at even addresses and bank B at odd ones. The indices are: direction 0, inversion 1, interrupt enable 2, compare value 3, mode 4, configuration 5, pull-up 6, flag 7, capture 8, port 9, output latch 10. Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R3: `gpio_oe_n`, `gpio_o` and `gpio_pu` show the direction, output latch and pull-up registers, with bank A in bits 7:0 and bank B in bits 15:8.
- R4: A port read returns, for input pins, the input level after the two-flop synchronizer XOR the inversion bit. For output pins it returns the latch bit.
- R5: With mode bit 0, an enabled input pin fires when its inverted level differs from its level in the previous cycle. Disabled pins and output pins never fire.
- R6: With mode bit 1, an enabled input pin fires in every cycle in which its inverted level differs from its compare bit, including again right after a clear.
- R7: A bank with no flag set loads a single flag bit, for the lowest-numbered pin among those firing. While any flag bit is set, no further bits are added.
- R8: When a bank's flag is loaded, its capture register takes that bank's port value in the same cycle. The capture then stays unchanged until the flag is cleared. Banks capture independently.
- R9: With configuration bit 0 clear, reading a bank's port register clears that bank's flag. With it set, only reading the capture register clears the flag. A clearing read takes priority over a new firing in the same cycle.
- R10: The configuration register is a single register reachable at both index-5 addresses. Only bits 6, 5, 3, 2, 1 and 0 are stored; bits 7 and 4 read as zero.
- R11: Configuration bit 6 makes each interrupt pin report the OR of both banks; otherwise `int_a` follows bank A and `int_b` follows bank B. Bit 1 sets active-high push-pull. Bit 2 selects open drain: the level is 0 and `*_oe_n` is 0 only while the interrupt is active.
- R12: Writes to the flag, capture and port registers, and to any index above 10, change nothing. Reads of indices above 10 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address: register index in bits 4:1, bank in bit 0 |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| gpio_i | input | 16 | Raw pin levels, bank A low byte |
| gpio_o | output | 16 | Output latch values |
| gpio_oe_n | output | 16 | Active-low output enables (direction register) |
| gpio_pu | output | 16 | Pull-up enables |
| int_a_o | output | 1 | Interrupt pin A level |
| int_a_oe_n | output | 1 | Interrupt pin A active-low enable |
| int_b_o | output | 1 | Interrupt pin B level |
| int_b_oe_n | output | 1 | Interrupt pin B active-low enable |

## Verification
The embedded properties check, on every cycle, that a flag never has more than one bit set. They also check that a flag only appears on a pin that was enabled and configured as an input, that the capture stays frozen while a flag is pending, that the chosen clearing read empties the flag, that mirrored push-pull pins agree, and that configuration reads take one cycle. Only the bench's scenarios can show the following: which pin wins when several fire together, the exact captured value, that compare mode fires again after a clear, the latency through the synchronizer, and that writes to read-only or unmapped addresses are dropped. A behavioural model in the bench is compared against every pin and read-data output on every clock.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_DIR  = 4'd0,
    IDX_POL  = 4'd1,
    IDX_IEN  = 4'd2,
    IDX_CMPV = 4'd3,
    IDX_MODE = 4'd4,
    IDX_CFG  = 4'd5,
    IDX_PULL = 4'd6,
    IDX_FLAG = 4'd7,
    IDX_CAP  = 4'd8,
    IDX_PORT = 4'd9,
    IDX_LAT  = 4'd10
  } reg_idx_t;

  localparam int CFG_MIRROR = 6;
  localparam int CFG_SEQOFF = 5;
  localparam int CFG_HWADR  = 3;
  localparam int CFG_ODR    = 2;
  localparam int CFG_HIPOL  = 1;
  localparam int CFG_CLRCAP = 0;
  localparam logic [7:0] CFG_MASK = (8'd1 << CFG_MIRROR) | (8'd1 << CFG_SEQOFF) |
                                    (8'd1 << CFG_HWADR)  | (8'd1 << CFG_ODR) |
                                    (8'd1 << CFG_HIPOL)  | (8'd1 << CFG_CLRCAP);
endpackage

// File: rtl/gx_bank.sv
module gx_bank
  import gx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_i,
  input  logic             clr_on_cap,
  output logic [W-1:0]     rdata,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     lat_o,
  output logic [W-1:0]     pu_o,
  output logic             irq_o
);
  logic [W-1:0] dir_q, pol_q, ien_q, cmp_q, mode_q, pull_q, flag_q, cap_q, lat_q;
  logic [W-1:0] s1_q, s2_q, prev_q;
  logic [W-1:0] lvl, port_v, hit, first;
  logic         clr_hit;

  assign lvl    = s2_q ^ pol_q;
  assign port_v = (dir_q & lvl) | (~dir_q & lat_q);
  assign hit    = ien_q & dir_q & ((mode_q & (lvl ^ cmp_q)) | (~mode_q & (lvl ^ prev_q)));
  assign first  = hit & (~hit + W'(1));
  assign clr_hit = rd_en && (clr_on_cap ? (idx == IDX_CAP) : (idx == IDX_PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      pol_q  <= '0;
      ien_q  <= '0;
      cmp_q  <= '0;
      mode_q <= '0;
      pull_q <= '0;
      flag_q <= '0;
      cap_q  <= '0;
      lat_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= lvl;
      if (clr_hit) begin
        flag_q <= '0;
      end else if (flag_q == '0 && hit != '0) begin
        flag_q <= first;
        cap_q  <= port_v;
      end
      if (wr_en) begin
        case (idx)
          IDX_DIR:  dir_q  <= wdata;
          IDX_POL:  pol_q  <= wdata;
          IDX_IEN:  ien_q  <= wdata;
          IDX_CMPV: cmp_q  <= wdata;
          IDX_MODE: mode_q <= wdata;
          IDX_PULL: pull_q <= wdata;
          IDX_LAT:  lat_q  <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IDX_DIR:  rdata = dir_q;
      IDX_POL:  rdata = pol_q;
      IDX_IEN:  rdata = ien_q;
      IDX_CMPV: rdata = cmp_q;
      IDX_MODE: rdata = mode_q;
      IDX_PULL: rdata = pull_q;
      IDX_FLAG: rdata = flag_q;
      IDX_CAP:  rdata = cap_q;
      IDX_PORT: rdata = port_v;
      IDX_LAT:  rdata = lat_q;
      default:  rdata = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign lat_o = lat_q;
  assign pu_o  = pull_q;
  assign irq_o = |flag_q;

  assert_flag_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_q));

  assert_flag_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |=> (flag_q == '0) || ((flag_q & $past(ien_q & dir_q)) != '0));

  assert_cap_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0 && !clr_hit) |=> $stable(cap_q));

  assert_clear_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (flag_q == '0));
endmodule

// File: rtl/gx_intout.sv
module gx_intout (
  input  logic act,
  input  logic hi_pol,
  input  logic odr,
  output logic lvl_o,
  output logic oe_n_o
);
  always_comb begin
    if (odr) begin
      lvl_o  = 1'b0;
      oe_n_o = ~act;
    end else begin
      lvl_o  = hi_pol ? act : ~act;
      oe_n_o = 1'b0;
    end
  end
endmodule

// File: rtl/gx_core.sv
module gx_core
  import gx_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W:0]      bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [BANK_W-1:0]   bus_rdata,
  input  logic [2*BANK_W-1:0] gpio_i,
  output logic [2*BANK_W-1:0] gpio_o,
  output logic [2*BANK_W-1:0] gpio_oe_n,
  output logic [2*BANK_W-1:0] gpio_pu,
  output logic                int_a_o,
  output logic                int_a_oe_n,
  output logic                int_b_o,
  output logic                int_b_oe_n
);
  localparam int NBANK = 2;

  logic [IDX_W-1:0]              idx;
  logic                          bsel;
  logic [BANK_W-1:0]             cfg_q, rdata_q, rd_mux;
  logic [NBANK-1:0][BANK_W-1:0]  b_rd, b_dir, b_lat, b_pu;
  logic [NBANK-1:0]              b_irq, act, i_lvl, i_oen;

  assign idx  = bus_addr[IDX_W:1];
  assign bsel = bus_addr[0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gx_bank #(.W(BANK_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr && (bsel == b[0])),
      .rd_en     (bus_rd && (bsel == b[0])),
      .idx       (idx),
      .wdata     (bus_wdata),
      .pin_i     (gpio_i[b*BANK_W +: BANK_W]),
      .clr_on_cap(cfg_q[CFG_CLRCAP]),
      .rdata     (b_rd[b]),
      .dir_o     (b_dir[b]),
      .lat_o     (b_lat[b]),
      .pu_o      (b_pu[b]),
      .irq_o     (b_irq[b])
    );
  end

  for (genvar k = 0; k < NBANK; k++) begin : g_int
    assign act[k] = cfg_q[CFG_MIRROR] ? (|b_irq) : b_irq[k];
    gx_intout u_out (
      .act   (act[k]),
      .hi_pol(cfg_q[CFG_HIPOL]),
      .odr   (cfg_q[CFG_ODR]),
      .lvl_o (i_lvl[k]),
      .oe_n_o(i_oen[k])
    );
  end

  assign rd_mux = (idx == IDX_CFG) ? cfg_q : b_rd[bsel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && idx == IDX_CFG) cfg_q <= bus_wdata & BANK_W'(CFG_MASK);
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign gpio_o     = b_lat;
  assign gpio_oe_n  = b_dir;
  assign gpio_pu    = b_pu;
  assign int_a_o    = i_lvl[0];
  assign int_a_oe_n = i_oen[0];
  assign int_b_o    = i_lvl[1];
  assign int_b_oe_n = i_oen[1];

  assert_mirror_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_MIRROR] && !cfg_q[CFG_ODR]) |-> (int_a_o == int_b_o));

  assert_cfg_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && idx == IDX_CFG) |=> (bus_rdata == $past(cfg_q)));
endmodule

// File: tb/tb_gx_core.sv
module tb_gx_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] gpio_i = '0;
  logic [15:0] gpio_o, gpio_oe_n, gpio_pu;
  logic        int_a_o, int_a_oe_n, int_b_o, int_b_oe_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gx_core dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .gpio_i(gpio_i),
    .gpio_o(gpio_o), .gpio_oe_n(gpio_oe_n), .gpio_pu(gpio_pu),
    .int_a_o(int_a_o), .int_a_oe_n(int_a_oe_n), .int_b_o(int_b_o), .int_b_oe_n(int_b_oe_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_dir[2], m_pol[2], m_ien[2], m_cmp[2], m_mode[2], m_pull[2];
  logic [7:0] m_flag[2], m_cap[2], m_lat[2], m_s1[2], m_s2[2], m_prev[2];
  logic [7:0] t_lv[2], t_pv[2], t_hit[2];
  logic [7:0] m_cfg, m_rd;

  function automatic logic [7:0] m_read(input int b, input int ix);
    case (ix)
      0: return m_dir[b];
      1: return m_pol[b];
      2: return m_ien[b];
      3: return m_cmp[b];
      4: return m_mode[b];
      5: return m_cfg;
      6: return m_pull[b];
      7: return m_flag[b];
      8: return m_cap[b];
      9: return t_pv[b];
      10: return m_lat[b];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        m_dir[b] = 8'hFF; m_pol[b] = 0; m_ien[b] = 0; m_cmp[b] = 0; m_mode[b] = 0;
        m_pull[b] = 0; m_flag[b] = 0; m_cap[b] = 0; m_lat[b] = 0;
        m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
      end
      m_cfg = 0; m_rd = 0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        t_lv[b] = m_s2[b] ^ m_pol[b];
        t_pv[b] = (m_dir[b] & t_lv[b]) | (~m_dir[b] & m_lat[b]);
        t_hit[b] = 0;
        for (int i = 0; i < 8; i++)
          if (m_ien[b][i] && m_dir[b][i] &&
              (m_mode[b][i] ? (t_lv[b][i] != m_cmp[b][i]) : (t_lv[b][i] != m_prev[b][i])))
            t_hit[b][i] = 1'b1;
      end
      if (bus_rd) m_rd = m_read(int'(bus_addr[0]), int'(bus_addr[4:1]));
      for (int b = 0; b < 2; b++) begin
        if (bus_rd && bus_addr[0] == b[0] &&
            ((m_cfg[0] && bus_addr[4:1] == 8) || (!m_cfg[0] && bus_addr[4:1] == 9))) begin
          m_flag[b] = 0;
        end else if (m_flag[b] == 0 && t_hit[b] != 0) begin
          for (int i = 7; i >= 0; i--) if (t_hit[b][i]) m_flag[b] = 8'd1 << i;
          m_cap[b] = t_pv[b];
        end
        m_prev[b] = t_lv[b];
      end
      if (bus_wr) begin
        case (int'(bus_addr[4:1]))
          0: m_dir[bus_addr[0]] = bus_wdata;
          1: m_pol[bus_addr[0]] = bus_wdata;
          2: m_ien[bus_addr[0]] = bus_wdata;
          3: m_cmp[bus_addr[0]] = bus_wdata;
          4: m_mode[bus_addr[0]] = bus_wdata;
          5: m_cfg = bus_wdata & 8'h6F;
          6: m_pull[bus_addr[0]] = bus_wdata;
          10: m_lat[bus_addr[0]] = bus_wdata;
          default: ;
        endcase
      end
      for (int b = 0; b < 2; b++) begin
        m_s2[b] = m_s1[b];
        m_s1[b] = gpio_i[b*8 +: 8];
      end
    end
  end

  function automatic logic [1:0] m_int(input logic a);
    if (m_cfg[2]) return {1'b0, ~a};
    return {m_cfg[1] ? a : ~a, 1'b0};
  endfunction

  logic ma, mb;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      ma = m_cfg[6] ? (m_flag[0] != 0 || m_flag[1] != 0) : (m_flag[0] != 0);
      mb = m_cfg[6] ? (m_flag[0] != 0 || m_flag[1] != 0) : (m_flag[1] != 0);
      chk("R2 R3 R11 model", {4'h0, gpio_o, gpio_oe_n, gpio_pu, int_a_o, int_a_oe_n, int_b_o, int_b_oe_n, bus_rdata},
          {4'h0, m_lat[1], m_lat[0], m_dir[1], m_dir[0], m_pull[1], m_pull[0], m_int(ma), m_int(mb), m_rd});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(req, {56'h0, bus_rdata}, {56'h0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 oe_n", {48'h0, gpio_oe_n}, 64'hFFFF);
    chk("R1 int idle", {60'h0, int_a_o, int_a_oe_n, int_b_o, int_b_oe_n}, 64'b1010);
    rd(5'd0, 8'hFF, "R1 R2 dir A");
    // R3 direction/latch/pull-up
    wr(5'd0, 8'h0F);
    wr(5'd20, 8'hA0);
    wr(5'd13, 8'h55);
    chk("R3 pins", {16'h0, gpio_o, gpio_oe_n, gpio_pu}, {16'h0, 16'h00A0, 16'hFF0F, 16'h5500});
    // R4 port read
    gpio_i = 16'h0003;
    idle(3);
    rd(5'd18, 8'hA3, "R4 port A");
    wr(5'd2, 8'h01);
    rd(5'd18, 8'hA2, "R4 port A inverted");
    // R12 read-only and unmapped
    wr(5'd18, 8'hFF);
    wr(5'd14, 8'hFF);
    wr(5'd22, 8'h77);
    rd(5'd20, 8'hA0, "R12 latch after port write");
    rd(5'd14, 8'h00, "R12 flag after write");
    rd(5'd22, 8'h00, "R12 unmapped read");
    // R5 change mode
    wr(5'd4, 8'h03);
    gpio_i = 16'h0001;
    idle(4);
    chk("R5 int_a active", {63'h0, int_a_o}, 64'h0);
    rd(5'd14, 8'h02, "R5 flag A");
    rd(5'd16, 8'hA0, "R8 capture A");
    rd(5'd14, 8'h02, "R9 capture read does not clear");
    rd(5'd18, 8'hA0, "R9 port read");
    rd(5'd14, 8'h00, "R9 cleared by port");
    // R7 simultaneous change, R8 frozen
    gpio_i = 16'h0002;
    idle(4);
    rd(5'd14, 8'h01, "R7 lowest pin");
    gpio_i = 16'h0000;
    idle(4);
    rd(5'd14, 8'h01, "R7 no extra bits");
    rd(5'd16, 8'hA3, "R8 capture frozen");
    rd(5'd18, 8'hA1, "R4 port A");
    idle(3);
    rd(5'd14, 8'h00, "R9 stays clear");
    // R6 compare mode on bank B
    wr(5'd7, 8'h00);
    wr(5'd9, 8'h80);
    wr(5'd5, 8'h80);
    idle(3);
    chk("R6 no fire when equal", {63'h0, int_b_o}, 64'h1);
    gpio_i = 16'h8000;
    idle(4);
    chk("R6 int_b active", {62'h0, int_a_o, int_b_o}, 64'b10);
    wr(5'd11, 8'h01);
    rd(5'd10, 8'h01, "R10 config via bank A");
    rd(5'd19, 8'h80, "R9 port B");
    rd(5'd15, 8'h80, "R9 port read no clear when cap mode");
    rd(5'd17, 8'h80, "R8 capture B");
    idle(2);
    rd(5'd15, 8'h80, "R6 refires after clear");
    gpio_i = 16'h0000;
    idle(4);
    rd(5'd17, 8'h80, "R9 capture read");
    idle(3);
    rd(5'd15, 8'h00, "R9 cleared by capture");
    wr(5'd10, 8'hFF);
    rd(5'd11, 8'h6F, "R10 reserved bits");
    wr(5'd10, 8'h01);
    // R11 interrupt pin options
    gpio_i = 16'h8000;
    idle(4);
    wr(5'd10, 8'h43);
    chk("R11 mirror active high", {62'h0, int_a_o, int_b_o}, 64'b11);
    wr(5'd10, 8'h45);
    chk("R11 open drain", {60'h0, int_a_o, int_a_oe_n, int_b_o, int_b_oe_n}, 64'b0000);
    wr(5'd10, 8'h01);
    chk("R11 separate active low", {60'h0, int_a_o, int_a_oe_n, int_b_o, int_b_oe_n}, 64'b1000);
    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule